// File: doc/BRIEF.md
# SDRAM burst interruption sequencer

This block is the column-access engine of a four-bank synchronous DRAM model. It takes one command per clock (read, write or no-operation) together with a bank and a column. It expands each read or write into a fixed burst of four column beats. A read returns its data after a CAS latency of three clocks. A small register array inside the block serves as the memory cells, so the block needs nothing outside it.

The block's main job is burst truncation. A newer read or write to any bank, at any column, cancels the beats of the burst in flight that have not yet been issued. When a write cuts into a read burst, the read driver shuts off on a fixed cycle. A per-clock data mask lets the controller blank the read beats that would overlap the incoming write data. The same mask also drops individual write beats.

The command and data pins follow the memory's own timing, so there is no valid/ready handshake. The block accepts a command on every clock and never pushes back. Read data cannot be stalled. The output-enable pin marks each cycle that carries a read beat.

Top module: `sdr_burst_seq`

## Requirements
- R1: The command code is 2'b01 for a read and 2'b10 for a write. Both 2'b00 and 2'b11 are no-operations: they write nothing and start no burst. The bank has two bits and the column has ten. Storage is addressed by the bank and the low STORE_W column bits, so columns that differ only above those bits reach the same word.
- R2: A read sampled at clock edge n drives beat i (i = 0..3) on rdata_o with rdata_oe_o high in the cycle that follows edge n+2+i, which is CAS latency 3. This holds unless the beat is cut off by a later command, the mask or a write.
- R3: Successive beats increment the low two column bits and wrap inside the aligned group of four. The upper column bits stay fixed.
- R4: A read at edge m cancels the unissued beats of an earlier read, whatever its bank or column. The earlier read's beats issued at edges before m still appear. Reads one clock apart therefore each yield exactly one beat.
- R5: The data of write beat 0 is taken at the edge of the write command. Beats 1, 2 and 3 are taken at the next three edges, at the addresses given by R3.
- R6: After a write at edge w, rdata_oe_o is low from the cycle after edge w+1 onward, whatever read beats were pending. The read beat driven after edge w is still output.
- R7: dqm_i sampled high at edge k forces rdata_oe_o low, and rdata_o to zero, in the cycle after edge k+1.
- R8: A write beat whose edge samples dqm_i high leaves the stored word unchanged.
- R9: A read or write that arrives during a write burst ends that burst. The old burst's beat at that edge, and every later beat, are not stored.
- R10: Whenever rdata_oe_o is low, rdata_o is all zeros.
- R11: While rst_n is low, rdata_oe_o and rdata_o are zero. A burst in flight when reset arrives produces no beats after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2 | Command code (R1) |
| bank_i | input | 2 | Bank select |
| col_i | input | 10 | Starting column of the burst |
| dqm_i | input | 1 | Data mask for read output and write input |
| wdata_i | input | 16 | Write data in |
| rdata_o | output | 16 | Read data out |
| rdata_oe_o | output | 1 | High in cycles that carry a read beat |

## Verification
The bench builds the block with its default parameters: CAS latency 3, a four-beat burst, sixteen stored words per bank and sixteen-bit data. With latency 3 the read path has exactly one delay stage between the burst generator and the output register. That lets the bench exercise a write flushing a pending beat, and a read beat escaping just before the flush. Because only the low four column bits index storage, a start column of 0x3F5 wraps its burst back onto the same word as column 0x004. This makes both the wrap rule and the aliasing rule visible from the data port.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_RSVD  = 2'b11
  } sdr_cmd_e;
endpackage

// File: rtl/sdr_burst_gen.sv
// Burst column generator: holds the beat being issued and steps through the
// wrapped column sequence (R3). A new command always reloads it (R4, R9).
module sdr_burst_gen #(
  parameter int BANK_W     = 2,
  parameter int LOC_W      = 4,
  parameter int BURST_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_rd_i,
  input  logic              start_wr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [LOC_W-1:0]  col_i,
  output logic              beat_vld_o,
  output logic              beat_wr_o,
  output logic [BANK_W-1:0] beat_bank_o,
  output logic [LOC_W-1:0]  beat_col_o
);
  localparam int CNT_W = BURST_LOG2;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'((1 << BURST_LOG2) - 1);
  localparam logic [CNT_W-1:0] LAST_M1  = CNT_W'((1 << BURST_LOG2) - 2);

  logic              vld_q, wr_q;
  logic [BANK_W-1:0] bank_q;
  logic [LOC_W-1:0]  col_q;
  logic [CNT_W-1:0]  left_q;

  function automatic logic [LOC_W-1:0] step_col(input logic [LOC_W-1:0] c);
    logic [LOC_W-1:0] r;
    r = c;
    r[BURST_LOG2-1:0] = c[BURST_LOG2-1:0] + 1'b1;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      wr_q   <= 1'b0;
      bank_q <= '0;
      col_q  <= '0;
      left_q <= '0;
    end else if (start_rd_i) begin
      vld_q  <= 1'b1;
      wr_q   <= 1'b0;
      bank_q <= bank_i;
      col_q  <= col_i;
      left_q <= LAST_IDX;
    end else if (start_wr_i) begin
      // beat 0 is stored directly at the command edge; hold beat 1 next (R5)
      vld_q  <= 1'b1;
      wr_q   <= 1'b1;
      bank_q <= bank_i;
      col_q  <= step_col(col_i);
      left_q <= LAST_M1;
    end else if (vld_q) begin
      if (left_q == '0) begin
        vld_q <= 1'b0;
      end else begin
        left_q <= left_q - 1'b1;
        col_q  <= step_col(col_q);
      end
    end
  end

  assign beat_vld_o  = vld_q;
  assign beat_wr_o   = wr_q;
  assign beat_bank_o = bank_q;
  assign beat_col_o  = col_q;
endmodule

// File: rtl/sdr_rd_pipe.sv
// Delay line that sets the read latency; a write flushes every stage (R6).
module sdr_rd_pipe #(
  parameter int BANK_W  = 2,
  parameter int LOC_W   = 4,
  parameter int CAS_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              in_vld_i,
  input  logic [BANK_W-1:0] in_bank_i,
  input  logic [LOC_W-1:0]  in_col_i,
  output logic              out_vld_o,
  output logic [BANK_W-1:0] out_bank_o,
  output logic [LOC_W-1:0]  out_col_o
);
  // generator and output register account for two clocks of the latency
  localparam int DEPTH = CAS_LAT - 2;

  generate
    if (DEPTH == 0) begin : g_direct
      assign out_vld_o  = in_vld_i;
      assign out_bank_o = in_bank_i;
      assign out_col_o  = in_col_i;
    end else begin : g_delay
      logic [DEPTH-1:0]  vld_q;
      logic [BANK_W-1:0] bank_q [DEPTH];
      logic [LOC_W-1:0]  col_q  [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= '0;
        end else if (flush_i) begin
          vld_q <= '0;
        end else begin
          vld_q[0] <= in_vld_i;
          for (int s = 1; s < DEPTH; s++) vld_q[s] <= vld_q[s-1];
        end
      end

      always_ff @(posedge clk) begin
        bank_q[0] <= in_bank_i;
        col_q[0]  <= in_col_i;
        for (int s = 1; s < DEPTH; s++) begin
          bank_q[s] <= bank_q[s-1];
          col_q[s]  <= col_q[s-1];
        end
      end

      assign out_vld_o  = vld_q[DEPTH-1];
      assign out_bank_o = bank_q[DEPTH-1];
      assign out_col_o  = col_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/sdr_cell_array.sv
// Register array standing in for the memory cells: one write port, one
// combinational read port.
module sdr_cell_array #(
  parameter int BANK_W  = 2,
  parameter int LOC_W   = 4,
  parameter int DATA_W  = 16
) (
  input  logic                    clk,
  input  logic                    we_i,
  input  logic [BANK_W+LOC_W-1:0] waddr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [BANK_W+LOC_W-1:0] raddr_i,
  output logic [DATA_W-1:0]       rdata_o
);
  localparam int WORDS = 1 << (BANK_W + LOC_W);

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
  import sdr_pkg::*;
#(
  parameter int BANK_W     = 2,
  parameter int COL_W      = 10,
  parameter int DATA_W     = 16,
  parameter int STORE_W    = 4,   // column bits that index storage (R1)
  parameter int BURST_LOG2 = 2,
  parameter int CAS_LAT    = 3    // must be 2 or more
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              dqm_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o
);
  localparam int ADDR_W = BANK_W + STORE_W;

  logic               is_rd, is_wr;
  logic               g_vld, g_wr;
  logic [BANK_W-1:0]  g_bank;
  logic [STORE_W-1:0] g_col;
  logic               p_vld;
  logic [BANK_W-1:0]  p_bank;
  logic [STORE_W-1:0] p_col;
  logic               we;
  logic [ADDR_W-1:0]  waddr;
  logic [DATA_W-1:0]  cell_rd;
  logic               dqm_q;

  // R1: codes 00 and 11 fall through as no-operation
  assign is_rd = (cmd_i == CMD_READ);
  assign is_wr = (cmd_i == CMD_WRITE);

  generate
    if (STORE_W < COL_W) begin : g_fold
      logic unused_col_hi;
      assign unused_col_hi = ^col_i[COL_W-1:STORE_W];
    end
  endgenerate

  sdr_burst_gen #(
    .BANK_W(BANK_W), .LOC_W(STORE_W), .BURST_LOG2(BURST_LOG2)
  ) u_gen (
    .clk(clk), .rst_n(rst_n),
    .start_rd_i(is_rd), .start_wr_i(is_wr),
    .bank_i(bank_i), .col_i(col_i[STORE_W-1:0]),
    .beat_vld_o(g_vld), .beat_wr_o(g_wr),
    .beat_bank_o(g_bank), .beat_col_o(g_col)
  );

  sdr_rd_pipe #(
    .BANK_W(BANK_W), .LOC_W(STORE_W), .CAS_LAT(CAS_LAT)
  ) u_pipe (
    .clk(clk), .rst_n(rst_n), .flush_i(is_wr),
    .in_vld_i(g_vld && !g_wr), .in_bank_i(g_bank), .in_col_i(g_col),
    .out_vld_o(p_vld), .out_bank_o(p_bank), .out_col_o(p_col)
  );

  // Write port: a new write takes beat 0 now (R5); a burst beat is stored
  // only if no new command arrives on its edge (R9); mask drops it (R8).
  always_comb begin
    we    = 1'b0;
    waddr = {bank_i, col_i[STORE_W-1:0]};
    if (is_wr) begin
      we = !dqm_i;
    end else if (!is_rd && g_vld && g_wr) begin
      we    = !dqm_i;
      waddr = {g_bank, g_col};
    end
  end

  sdr_cell_array #(
    .BANK_W(BANK_W), .LOC_W(STORE_W), .DATA_W(DATA_W)
  ) u_cells (
    .clk(clk), .we_i(we), .waddr_i(waddr), .wdata_i(wdata_i),
    .raddr_i({p_bank, p_col}), .rdata_o(cell_rd)
  );

  // Output register; mask applies one edge after it is sampled (R7, R10)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dqm_q      <= 1'b0;
      rdata_oe_o <= 1'b0;
      rdata_o    <= '0;
    end else begin
      dqm_q <= dqm_i;
      if (p_vld && !dqm_q) begin
        rdata_oe_o <= 1'b1;
        rdata_o    <= cell_rd;
      end else begin
        rdata_oe_o <= 1'b0;
        rdata_o    <= '0;
      end
    end
  end
endmodule

// File: rtl/sdr_burst_seq_chk.sv
module sdr_burst_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cmd_i,
  input logic              dqm_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rdata_oe_o
);
  // edges seen since reset, saturating, so $past never reaches before reset
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_ZERO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe_o |-> (rdata_o == '0)); // R10

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !rdata_oe_o); // R11

  AST_WRITE_TURNS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(cmd_i, 2) == 2'b10) |-> !rdata_oe_o); // R6

  AST_DQM_MASKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(dqm_i, 2)) |-> !rdata_oe_o); // R7

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(cmd_i, 3) == 2'b01 && $past(cmd_i, 2) != 2'b10
     && !$past(dqm_i, 2)) |-> rdata_oe_o); // R2
endmodule

bind sdr_burst_seq sdr_burst_seq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sdr_burst_seq_test.sv
`timescale 1ns/1ps
module sdr_burst_seq_test;
  localparam logic [1:0] N = 2'b00;
  localparam logic [1:0] R = 2'b01;
  localparam logic [1:0] W = 2'b10;

  typedef struct packed {
    logic [1:0]  cmd;
    logic [1:0]  bank;
    logic [9:0]  col;
    logic        dqm;
    logic [15:0] wd;
    logic        oe;
    logic [15:0] exp;
    logic [3:0]  req;
  } row_t;

  // One row per clock: inputs for edge j, expected outputs after edge j.
  localparam row_t TBL [61] = '{
    '{W, 2'd0, 10'h004, 1'b0, 16'h1000, 1'b0, 16'h0000, 4'd5}, // 0  R5
    '{N, 2'd0, 10'h000, 1'b0, 16'h1001, 1'b0, 16'h0000, 4'd5},
    '{N, 2'd0, 10'h000, 1'b0, 16'h1002, 1'b0, 16'h0000, 4'd5},
    '{N, 2'd0, 10'h000, 1'b0, 16'h1003, 1'b0, 16'h0000, 4'd5},
    '{W, 2'd1, 10'h00A, 1'b0, 16'h2000, 1'b0, 16'h0000, 4'd3}, // 4  R3 wrap
    '{N, 2'd0, 10'h000, 1'b0, 16'h2001, 1'b0, 16'h0000, 4'd3},
    '{N, 2'd0, 10'h000, 1'b0, 16'h2002, 1'b0, 16'h0000, 4'd3},
    '{N, 2'd0, 10'h000, 1'b0, 16'h2003, 1'b0, 16'h0000, 4'd3},
    '{W, 2'd2, 10'h000, 1'b0, 16'h5000, 1'b0, 16'h0000, 4'd5}, // 8
    '{N, 2'd0, 10'h000, 1'b0, 16'h5001, 1'b0, 16'h0000, 4'd5},
    '{N, 2'd0, 10'h000, 1'b0, 16'h5002, 1'b0, 16'h0000, 4'd5},
    '{N, 2'd0, 10'h000, 1'b0, 16'h5003, 1'b0, 16'h0000, 4'd5},
    '{W, 2'd2, 10'h000, 1'b0, 16'h3000, 1'b0, 16'h0000, 4'd5}, // 12
    '{N, 2'd0, 10'h000, 1'b1, 16'h3001, 1'b0, 16'h0000, 4'd8}, // R8 masked beat
    '{N, 2'd0, 10'h000, 1'b0, 16'h3002, 1'b0, 16'h0000, 4'd5},
    '{W, 2'd3, 10'h00C, 1'b0, 16'h4000, 1'b0, 16'h0000, 4'd9}, // 15 R9 ends bank2
    '{N, 2'd0, 10'h000, 1'b0, 16'h4001, 1'b0, 16'h0000, 4'd5},
    '{N, 2'd0, 10'h000, 1'b0, 16'h4002, 1'b0, 16'h0000, 4'd5},
    '{N, 2'd0, 10'h000, 1'b0, 16'h4003, 1'b0, 16'h0000, 4'd5},
    '{R, 2'd0, 10'h3F5, 1'b0, 16'h0000, 1'b0, 16'h0000, 4'd2}, // 19 R2 read
    '{N, 2'd0, 10'h000, 1'b0, 16'h0000, 1'b0, 16'h0000, 4'd2},
    '{N, 2'd0, 10'h000, 1'b0, 16'h0000, 1'b1, 16'h1001, 4'd2}, // R2 latency 3
    '{N, 2'd0, 10'h000, 1'b0, 16'h0000, 1'b1, 16'h1002, 4'd2},
    '{N, 2'd0, 10'h000, 1'b0, 16'h0000, 1'b1, 16'h1003, 4'd3},
    '{N, 2'd0, 10'h000, 1'b0, 16'h0000, 1'b1, 16'h1000, 4'd1}, // R1 alias, R3 wrap
    '{R, 2'd1, 10'h008, 1'b0, 16'h0000, 1'b0, 16'h0000, 4'd2}, // 25
    '{R, 2'd2, 10'h001, 1'b0, 16'h0000, 1'b0, 16'h0000, 4'd4}, // R4 back-to-back
    '{N, 2'd0, 10'h000, 1'b0, 16'h0000, 1'b1, 16'h2002, 4'd4}, // R4 one beat only
    '{R, 2'd3, 10'h00E, 1'b0, 16'h0000, 1'b1, 16'h5001, 4'd8}, // R8 word kept
    '{N, 2'd0, 10'h000, 1'b0, 16'h0000, 1'b1, 16'h3002, 4'd4},
    '{N, 2'd0, 10'h000, 1'b0, 16'h0000, 1'b1, 16'h4002, 4'd4}, // R4 new burst
    '{N, 2'd0, 10'h000, 1'b0, 16'h0000, 1'b1, 16'h4003, 4'd3},
    '{N, 2'd0, 10'h000, 1'b0, 16'h0000, 1'b1, 16'h4000, 4'd3},
    '{N, 2'd0, 10'h000, 1'b0, 16'h0000, 1'b1, 16'h4001, 4'd3},
    '{R, 2'd1, 10'h00A, 1'b0, 16'h0000, 1'b0, 16'h0000, 4'd2}, // 34
    '{N, 2'd0, 10'h000, 1'b1, 16'h0000, 1'b0, 16'h0000, 4'd7},
    '{W, 2'd0, 10'h000, 1'b0, 16'h6000, 1'b0, 16'h0000, 4'd7}, // R7 masked beat
    '{N, 2'd0, 10'h000, 1'b0, 16'h6001, 1'b0, 16'h0000, 4'd6}, // R6 driver off
    '{N, 2'd0, 10'h000, 1'b0, 16'h6002, 1'b0, 16'h0000, 4'd6},
    '{N, 2'd0, 10'h000, 1'b0, 16'h6003, 1'b0, 16'h0000, 4'd6},
    '{R, 2'd0, 10'h000, 1'b0, 16'h0000, 1'b0, 16'h0000, 4'd5}, // 40
    '{N, 2'd0, 10'h000, 1'b0, 16'h0000, 1'b0, 16'h0000, 4'd5},
    '{N, 2'd0, 10'h000, 1'b0, 16'h0000, 1'b1, 16'h6000, 4'd5}, // R5 data landed
    '{W, 2'd3, 10'h000, 1'b0, 16'h7000, 1'b1, 16'h6001, 4'd6}, // R6 last beat out
    '{N, 2'd0, 10'h000, 1'b0, 16'h7001, 1'b0, 16'h0000, 4'd6}, // R6 flushed
    '{N, 2'd0, 10'h000, 1'b0, 16'h7002, 1'b0, 16'h0000, 4'd6},
    '{N, 2'd0, 10'h000, 1'b0, 16'h7003, 1'b0, 16'h0000, 4'd6},
    '{R, 2'd3, 10'h002, 1'b0, 16'h0000, 1'b0, 16'h0000, 4'd2}, // 47
    '{N, 2'd0, 10'h000, 1'b0, 16'h0000, 1'b0, 16'h0000, 4'd2},
    '{N, 2'd0, 10'h000, 1'b0, 16'h0000, 1'b1, 16'h7002, 4'd2},
    '{N, 2'd0, 10'h000, 1'b1, 16'h0000, 1'b1, 16'h7003, 4'd7},
    '{N, 2'd0, 10'h000, 1'b0, 16'h0000, 1'b0, 16'h0000, 4'd7}, // R7 read mask
    '{N, 2'd0, 10'h000, 1'b0, 16'h0000, 1'b1, 16'h7001, 4'd7},
    '{W, 2'd0, 10'h004, 1'b0, 16'h8000, 1'b0, 16'h0000, 4'd9}, // 53
    '{N, 2'd0, 10'h000, 1'b0, 16'h8001, 1'b0, 16'h0000, 4'd9},
    '{R, 2'd0, 10'h004, 1'b0, 16'h8002, 1'b0, 16'h0000, 4'd9}, // R9 read ends write
    '{N, 2'd0, 10'h000, 1'b0, 16'h8003, 1'b0, 16'h0000, 4'd9},
    '{N, 2'd0, 10'h000, 1'b0, 16'h0000, 1'b1, 16'h8000, 4'd9},
    '{N, 2'd0, 10'h000, 1'b0, 16'h0000, 1'b1, 16'h8001, 4'd9},
    '{N, 2'd0, 10'h000, 1'b0, 16'h0000, 1'b1, 16'h1002, 4'd9}, // R9 not written
    '{N, 2'd0, 10'h000, 1'b0, 16'h0000, 1'b1, 16'h1003, 4'd9}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cmd;
  logic [1:0]  bank;
  logic [9:0]  col;
  logic        dqm;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        rdata_oe;

  int checks = 0;
  int bad    = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sdr_burst_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank), .col_i(col),
    .dqm_i(dqm), .wdata_i(wdata), .rdata_o(rdata), .rdata_oe_o(rdata_oe)
  );

  task automatic check(input int req, input logic exp_oe, input logic [15:0] exp_d,
                       input string what);
    checks++;
    if (rdata_oe !== exp_oe || rdata !== exp_d) begin
      bad++;
      $display("FAIL R%0d %s: oe=%0b data=%h, expected oe=%0b data=%h",
               req, what, rdata_oe, rdata, exp_oe, exp_d);
    end
  endtask

  task automatic drive(input logic [1:0] c, input logic [1:0] b, input logic [9:0] a,
                       input logic m, input logic [15:0] d);
    cmd = c; bank = b; col = a; dqm = m; wdata = d;
  endtask

  task automatic step(input logic [1:0] c, input logic [1:0] b, input logic [9:0] a,
                      input logic m, input logic [15:0] d);
    drive(c, b, a, m, d);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    drive(N, 2'd0, 10'h000, 1'b0, 16'h0000);
    repeat (2) @(negedge clk);
    check(11, 1'b0, 16'h0000, "reset state"); // R11
    rst_n = 1'b1;

    // table walk
    drive(TBL[0].cmd, TBL[0].bank, TBL[0].col, TBL[0].dqm, TBL[0].wd);
    for (int j = 0; j < 61; j++) begin
      @(posedge clk);
      @(negedge clk);
      check(int'(TBL[j].req), TBL[j].oe, TBL[j].exp, $sformatf("row %0d", j));
      if (j < 60)
        drive(TBL[j+1].cmd, TBL[j+1].bank, TBL[j+1].col, TBL[j+1].dqm, TBL[j+1].wd);
    end

    // R1: code 11 writes nothing and starts no burst
    step(2'b11, 2'd0, 10'h000, 1'b0, 16'hDEAD);
    check(1, 1'b0, 16'h0000, "code 11 no output");
    step(R, 2'd0, 10'h000, 1'b0, 16'h0000);
    check(1, 1'b0, 16'h0000, "code 11 no burst");
    step(N, 2'd0, 10'h000, 1'b0, 16'h0000);
    check(1, 1'b0, 16'h0000, "code 11 no burst, second cycle");
    step(N, 2'd0, 10'h000, 1'b0, 16'h0000);
    check(1, 1'b1, 16'h6000, "code 11 left word intact");

    // R11: reset in the middle of a burst
    rst_n = 1'b0;
    #1;
    check(11, 1'b0, 16'h0000, "async reset mid-burst");
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step(N, 2'd0, 10'h000, 1'b0, 16'h0000);
      check(11, 1'b0, 16'h0000, $sformatf("burst dropped after reset, cycle %0d", k));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog (all requirements): actual=still running expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule